// File: doc/BRIEF.md
# Serial Audio Output Formatter

This block turns parallel stereo audio words into a serial audio stream. It makes its own bit clock by dividing the system clock. It drives a word-select line and several serial data lanes. Each lane carries its own left and right word. Every frame holds two slots of fixed width: the left slot is sent while word-select is low, and the right slot while it is high.

A two-bit mode input picks the framing. The choices are the classic delayed-MSB framing, MSB-aligned framing, LSB-aligned framing with a programmable number of valid bits, or a raw pass-through that sends a pre-built 32-bit IEC60958 subframe exactly as given. The block captures the words, the mode and the width only at the start of a frame, so a frame is never mixed. A one-cycle strobe asks the host for the next pair. A control-override input replaces the data lanes with a four-bit control word.

Top module: `serial_audio_fmt`

## Requirements
- R1: The mode input is decoded as 00 = delayed-MSB framing, 01 = LSB-aligned, 10 = MSB-aligned, 11 = raw subframe pass-through. The captured mode resets to 00.
- R2: Each slot is 32 bit clocks long. The left slot comes first with word-select low, and the right slot follows with word-select high. In mode 00 the first bit of a slot is 0. The next 24 bits are sample bits 23 down to 0, and the rest of the slot is 0.
- R3: In mode 10, sample bits 23 down to 0 fill the first 24 bits of the slot, starting on the bit where word-select changes. The remaining bits are 0.
- R4: In mode 01, with an effective width w, the slot starts with 32-w zeros. Sample bits w-1 down to 0 follow, so bit 0 lands on the last bit of the slot. The effective width equals the width input when that input is between 1 and 24, and is 24 otherwise. The captured width resets to 24.
- R5: In mode 11, all 32 bits of each word are sent unchanged, bit 0 first.
- R6: While the override input is 1, data lane i shows bit i of the control word, one system clock after the inputs. When the override is 0, audio is shown. The registered override resets to 0.
- R7: Sample words are captured only at the start of a left slot. Each capture is followed by a one-cycle ready pulse, so ready pulses come exactly one frame (64 bit clocks) apart.
- R8: A change to mode, width or sample inputs in the middle of a frame does not alter that frame. It takes effect from the next frame.
- R9: The bit clock period is 2*HALF_DIV system clocks. Word-select and data change together with the falling bit-clock edge. In reset the bit clock is 0, word-select is 1, the data lanes are 0 and ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgMode | input | 2 | Framing select (R1 encoding) |
| cfgWidth | input | 5 | Valid bits in LSB-aligned mode |
| ctrlEn | input | 1 | Override data lanes with control word |
| ctrlWord | input | 4 | Control bits, bit i to lane i |
| leftIn | input | 128 | Left words, lane i at bits 32i+31..32i |
| rightIn | input | 128 | Right words, same lane packing |
| sampleReady | output | 1 | One-cycle pulse after a sample pair is captured |
| bclk | output | 1 | Serial bit clock |
| ws | output | 1 | Word select, 0 = left, 1 = right |
| sdOut | output | 4 | Serial data lanes |

## Verification
The bench captures whole frames and compares them bit by bit. It targets the one-bit offset between delayed-MSB and MSB-aligned framing; a swapped decode or an off-by-one here shifts every word by a bit. The LSB-aligned mode is run at widths 24, 16, 0 and 31, so that a missing clamp or a wrong pad count shows up as stray or shifted bits. The bench also changes the mode and the samples in the middle of a frame, which catches a design that captures outside the frame boundary and emits a torn frame. Finally it checks the control override and the spacing of the bit clock and the ready pulses, so a divider or pulse error is visible.

// File: rtl/audfmt_pkg.sv
package audfmt_pkg;
  typedef enum logic [1:0] {
    FMT_I2S = 2'b00,
    FMT_RJ  = 2'b01,
    FMT_LJ  = 2'b10,
    FMT_RAW = 2'b11
  } fmtMode_t;

  typedef struct packed {
    logic tick;   // falling bit-clock edge: advance one bit
    logic load;   // first bit of a new frame: capture words and settings
  } fmtStrobe_t;
endpackage

// File: rtl/fmt_ctrl.sv
module fmt_ctrl
  import audfmt_pkg::*;
#(
  parameter int SLOT_W      = 32,
  parameter int HALF_DIV    = 2,
  parameter int W_BITS      = 5,
  parameter int RESET_WIDTH = 24,
  localparam int POS_W      = $clog2(2 * SLOT_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cfgMode,
  input  logic [W_BITS-1:0] cfgWidth,
  output logic              bclk,
  output logic              ws,
  output logic [POS_W-1:0]  pos,
  output fmtStrobe_t        strobes,
  output fmtMode_t          activeMode,
  output logic [W_BITS-1:0] activeWidth,
  output logic              sampleReady
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CNT_W-1:0] divCnt;
  logic             lastCnt;

  assign lastCnt      = (divCnt == CNT_W'(HALF_DIV - 1));
  assign strobes.tick = lastCnt && bclk;
  assign strobes.load = strobes.tick && (pos == '1);
  assign ws           = pos[POS_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt      <= '0;
      bclk        <= 1'b0;
      pos         <= '1;
      activeMode  <= FMT_I2S;
      activeWidth <= W_BITS'(RESET_WIDTH);
      sampleReady <= 1'b0;
    end else begin
      sampleReady <= strobes.load;
      if (lastCnt) begin
        divCnt <= '0;
        bclk   <= ~bclk;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
      if (strobes.tick) pos <= pos + 1'b1;
      if (strobes.load) begin
        activeMode  <= fmtMode_t'(cfgMode);
        activeWidth <= cfgWidth;
      end
    end
  end

  // R9: the bit clock only moves when the divider wraps
  a_r9_bclk_hold: assert property (@(posedge clk) disable iff (!rstN)
    !lastCnt |=> $stable(bclk));
  // R2: word select moves only on a falling bit-clock edge
  a_r2_ws_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.tick |=> $stable(ws));
  // R8: settings hold for the whole frame
  a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> ($stable(activeMode) && $stable(activeWidth)));
  // R7: ready is a single-cycle pulse
  a_r7_ready_pulse: assert property (@(posedge clk) disable iff (!rstN)
    sampleReady |=> !sampleReady);
endmodule

// File: rtl/fmt_dp.sv
module fmt_dp
  import audfmt_pkg::*;
#(
  parameter int SLOT_W = 32,
  parameter int DATA_W = 24,
  parameter int LANES  = 4,
  parameter int W_BITS = 5,
  localparam int POS_W = $clog2(2 * SLOT_W),
  localparam int BUS_W = LANES * SLOT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  fmtStrobe_t        strobes,
  input  logic [POS_W-1:0]  pos,
  input  fmtMode_t          activeMode,
  input  logic [W_BITS-1:0] activeWidth,
  input  logic [BUS_W-1:0]  leftIn,
  input  logic [BUS_W-1:0]  rightIn,
  input  logic              ctrlEn,
  input  logic [LANES-1:0]  ctrlWord,
  output logic [LANES-1:0]  sdOut
);
  localparam int KW = $clog2(SLOT_W);

  logic [BUS_W-1:0]  leftQ, rightQ;
  logic              ctrlEnQ;
  logic [LANES-1:0]  ctrlQ;
  logic [LANES-1:0]  audioBit;
  logic [KW-1:0]     slotBit;
  logic              inRight;
  logic [W_BITS-1:0] effW;

  assign slotBit = pos[KW-1:0];
  assign inRight = pos[POS_W-1];
  assign effW    = (activeWidth == '0 || int'(activeWidth) > DATA_W)
                   ? W_BITS'(DATA_W) : activeWidth;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      leftQ   <= '0;
      rightQ  <= '0;
      ctrlEnQ <= 1'b0;
      ctrlQ   <= '0;
    end else begin
      ctrlEnQ <= ctrlEn;
      ctrlQ   <= ctrlWord;
      if (strobes.load) begin
        leftQ  <= leftIn;
        rightQ <= rightIn;
      end
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [SLOT_W-1:0] word;
    logic [KW-1:0]     idx;
    logic              hit;

    assign word = inRight ? rightQ[i*SLOT_W +: SLOT_W] : leftQ[i*SLOT_W +: SLOT_W];

    always_comb begin
      idx = '0;
      hit = 1'b0;
      unique case (activeMode)
        FMT_I2S: begin
          hit = (int'(slotBit) >= 1) && (int'(slotBit) <= DATA_W);
          idx = KW'(DATA_W - int'(slotBit));
        end
        FMT_LJ: begin
          hit = int'(slotBit) < DATA_W;
          idx = KW'(DATA_W - 1 - int'(slotBit));
        end
        FMT_RJ: begin
          hit = int'(slotBit) >= SLOT_W - int'(effW);
          idx = KW'(SLOT_W - 1 - int'(slotBit));
        end
        FMT_RAW: begin
          hit = 1'b1;
          idx = slotBit;
        end
        default: begin
          hit = 1'b0;
          idx = '0;
        end
      endcase
      audioBit[i] = hit & word[idx];
    end

    assign sdOut[i] = ctrlEnQ ? ctrlQ[i] : audioBit[i];
  end

  // R7: captured words stay put between frame starts
  a_r7_shadow_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> ($stable(leftQ) && $stable(rightQ)));
  // R4: leading pad of the LSB-aligned slot is zero on every lane
  a_r4_rj_pad: assert property (@(posedge clk) disable iff (!rstN)
    (activeMode == FMT_RJ && !ctrlEnQ && int'(slotBit) < SLOT_W - int'(effW))
      |-> (sdOut == '0));
endmodule

// File: rtl/serial_audio_fmt.sv
module serial_audio_fmt
  import audfmt_pkg::*;
#(
  parameter int SLOT_W      = 32,
  parameter int DATA_W      = 24,
  parameter int LANES       = 4,
  parameter int HALF_DIV    = 2,
  parameter int W_BITS      = 5,
  parameter int RESET_WIDTH = 24
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [1:0]               cfgMode,
  input  logic [W_BITS-1:0]        cfgWidth,
  input  logic                     ctrlEn,
  input  logic [LANES-1:0]         ctrlWord,
  input  logic [LANES*SLOT_W-1:0]  leftIn,
  input  logic [LANES*SLOT_W-1:0]  rightIn,
  output logic                     sampleReady,
  output logic                     bclk,
  output logic                     ws,
  output logic [LANES-1:0]         sdOut
);
  localparam int POS_W = $clog2(2 * SLOT_W);

  fmtStrobe_t        strobes;
  logic [POS_W-1:0]  pos;
  fmtMode_t          activeMode;
  logic [W_BITS-1:0] activeWidth;

  fmt_ctrl #(
    .SLOT_W(SLOT_W), .HALF_DIV(HALF_DIV), .W_BITS(W_BITS), .RESET_WIDTH(RESET_WIDTH)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgWidth(cfgWidth),
    .bclk(bclk), .ws(ws), .pos(pos), .strobes(strobes),
    .activeMode(activeMode), .activeWidth(activeWidth), .sampleReady(sampleReady)
  );

  fmt_dp #(
    .SLOT_W(SLOT_W), .DATA_W(DATA_W), .LANES(LANES), .W_BITS(W_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .pos(pos),
    .activeMode(activeMode), .activeWidth(activeWidth),
    .leftIn(leftIn), .rightIn(rightIn), .ctrlEn(ctrlEn), .ctrlWord(ctrlWord),
    .sdOut(sdOut)
  );

  // R6: override shows the control word one clock later
  a_r6_ctrl_override: assert property (@(posedge clk) disable iff (!rstN)
    ctrlEn |=> (sdOut == $past(ctrlWord)));
endmodule

// File: tb/sim_serial_audio_fmt.sv
`timescale 1ns/1ps
module sim_serial_audio_fmt;
  localparam int HALF = 2;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [1:0]   cfgMode = 2'b00;
  logic [4:0]   cfgWidth = 5'd24;
  logic         ctrlEn = 1'b0;
  logic [3:0]   ctrlWord = 4'h0;
  logic [127:0] leftIn = '0;
  logic [127:0] rightIn = '0;
  logic         sampleReady, bclk, ws;
  logic [3:0]   sdOut;

  int nChecks = 0;
  int nFail = 0;

  logic       wsCap [64];
  logic [3:0] sdCap [64];
  logic [1:0]   chgMode;
  logic [127:0] chgL, chgR;

  always #2.5 clk = ~clk;

  serial_audio_fmt u0 (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgWidth(cfgWidth),
    .ctrlEn(ctrlEn), .ctrlWord(ctrlWord), .leftIn(leftIn), .rightIn(rightIn),
    .sampleReady(sampleReady), .bclk(bclk), .ws(ws), .sdOut(sdOut)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] pattern(input logic [31:0] seed);
    logic [127:0] v;
    for (int i = 0; i < 4; i++) v[i*32 +: 32] = seed ^ (32'h1357_9BDF * (i + 1));
    return v;
  endfunction

  function automatic logic expBit(input logic [1:0] m, input int w,
                                  input logic [31:0] word, input int k);
    int e;
    e = (w == 0 || w > 24) ? 24 : w;
    case (m)
      2'b00: return (k >= 1 && k <= 24) ? word[24 - k] : 1'b0;
      2'b10: return (k < 24) ? word[23 - k] : 1'b0;
      2'b01: return (k >= 32 - e) ? word[31 - k] : 1'b0;
      default: return word[k];
    endcase
  endfunction

  task automatic waitReady();
    @(negedge clk);
    while (!sampleReady) @(negedge clk);
  endtask

  // capture 64 bits at bit-clock rising edges; optionally change inputs at bit chgAt
  task automatic captureFrame(input int chgAt);
    for (int b = 0; b < 64; b++) begin
      if (b == chgAt) begin
        cfgMode = chgMode;
        leftIn = chgL;
        rightIn = chgR;
      end
      while (bclk) @(negedge clk);
      while (!bclk) @(negedge clk);
      wsCap[b] = ws;
      sdCap[b] = sdOut;
    end
  endtask

  task automatic verifyFrame(input logic [1:0] m, input int w, input logic [127:0] lv,
                             input logic [127:0] rv, input string req);
    logic [63:0] aWs, eWs;
    for (int k = 0; k < 64; k++) begin
      aWs[k] = wsCap[k];
      eWs[k] = (k >= 32);
    end
    chk(aWs == eWs, req, "word-select frame", aWs, eWs);
    for (int ln = 0; ln < 4; ln++) begin
      logic [63:0] a, e;
      for (int k = 0; k < 64; k++) begin
        a[k] = sdCap[k][ln];
        e[k] = (k < 32) ? expBit(m, w, lv[ln*32 +: 32], k)
                        : expBit(m, w, rv[ln*32 +: 32], k - 32);
      end
      chk(a == e, req, $sformatf("lane %0d frame", ln), a, e);
    end
  endtask

  task automatic runFrame(input logic [1:0] m, input int w, input logic [31:0] seed,
                          input string req);
    logic [127:0] lv, rv;
    lv = pattern(seed);
    rv = pattern(~seed ^ 32'h00FF_A55A);
    cfgMode = m;
    cfgWidth = 5'(w);
    leftIn = lv;
    rightIn = rv;
    waitReady();
    captureFrame(-1);
    verifyFrame(m, w, lv, rv, req);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(bclk == 1'b0 && ws == 1'b1 && sdOut == 4'h0 && sampleReady == 1'b0, "R9",
        "reset outputs", {60'h0, bclk, ws, sampleReady, |sdOut}, 64'h4);
  endtask

  task automatic testI2s();
    runFrame(2'b00, 24, 32'hC0FF_EE11, "R1/R2 delayed-MSB");
    runFrame(2'b00, 24, 32'h8000_0001, "R2 delayed-MSB edge bits");
  endtask

  task automatic testLj();
    runFrame(2'b10, 24, 32'h0080_0001, "R3 MSB-aligned");
    runFrame(2'b10, 24, 32'h5A5A_3C3C, "R3 MSB-aligned pattern");
  endtask

  task automatic testRj();
    runFrame(2'b01, 24, 32'h00F0_0F81, "R4 width 24");
    runFrame(2'b01, 16, 32'hFFFF_8001, "R4 width 16");
    runFrame(2'b01, 0,  32'hDEAD_BEEF, "R4 width 0 clamps");
    runFrame(2'b01, 31, 32'h9ABC_DEF0, "R4 width 31 clamps");
    runFrame(2'b01, 1,  32'hFFFF_FFFF, "R4 width 1");
  endtask

  task automatic testRaw();
    runFrame(2'b11, 24, 32'h8000_0003, "R5 raw subframe");
  endtask

  task automatic testMidFrame();
    logic [127:0] lA, rA;
    lA = pattern(32'h1234_5678);
    rA = pattern(32'h0F0F_F0F0);
    chgL = pattern(32'hCAFE_0001);
    chgR = pattern(32'h7777_8888);
    chgMode = 2'b10;
    cfgMode = 2'b00;
    cfgWidth = 5'd24;
    leftIn = lA;
    rightIn = rA;
    waitReady();
    captureFrame(10);
    verifyFrame(2'b00, 24, lA, rA, "R8/R7 mid-frame change ignored");
    waitReady();
    captureFrame(-1);
    verifyFrame(2'b10, 24, chgL, chgR, "R8 change applied next frame");
  endtask

  task automatic testOverride();
    bit ok;
    @(negedge clk);
    ctrlWord = 4'b1010;
    ctrlEn = 1'b1;
    @(negedge clk);
    ok = 1'b1;
    for (int c = 0; c < 40; c++) begin
      if (sdOut != 4'b1010) ok = 1'b0;
      @(negedge clk);
    end
    chk(ok, "R6", "override held", {60'h0, sdOut}, 64'hA);
    ctrlWord = 4'b0101;
    @(negedge clk);
    chk(sdOut == 4'b0101, "R6", "override follows word", {60'h0, sdOut}, 64'h5);
    ctrlEn = 1'b0;
    runFrame(2'b10, 24, 32'h3141_5926, "R6 audio after override");
  endtask

  task automatic testTiming();
    int n;
    while (bclk) @(negedge clk);
    while (!bclk) @(negedge clk);
    n = 0;
    while (bclk) begin @(negedge clk); n++; end
    while (!bclk) begin @(negedge clk); n++; end
    chk(n == 2 * HALF, "R9", "bit clock period", 64'(n), 64'(2 * HALF));
    waitReady();
    @(negedge clk);
    chk(sampleReady == 1'b0, "R7", "ready width", {63'h0, sampleReady}, 64'h0);
    n = 1;
    while (!sampleReady) begin @(negedge clk); n++; end
    chk(n == 64 * 2 * HALF, "R7", "ready spacing", 64'(n), 64'(64 * 2 * HALF));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testI2s();
    testLj();
    testRj();
    testRaw();
    testMidFrame();
    testOverride();
    testTiming();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule